// File: doc/BRIEF.md
# Instruction Stream Length and Cycle Decoder

This block sits beside a 16-bit instruction fetch path and watches the words that go past, one valid word per clock. It finds where each instruction begins and ends. Then it reports, once per instruction, what kind of instruction it was and how it addresses its operands. It turns the register number and the two-bit mode field into the full operand modes: register, indexed, indirect, auto-increment, symbolic, absolute, immediate and generated constant. From those modes it works out how many extension words belong to the instruction and how many execution cycles it should cost. Extension words are soaked up and handed out with the instruction that owns them. The block never touches memory and never executes anything.

The controller has three states. ST_OPC waits for an opcode word. ST_SRC_EXT waits for the source extension word. ST_DST_EXT waits for the destination extension word. The transitions are:
- opc_done, ST_OPC to ST_OPC: a one-word instruction completes.
- opc_to_src, ST_OPC to ST_SRC_EXT: a source extension word is pending.
- opc_to_dst, ST_OPC to ST_DST_EXT: only a destination extension word is pending.
- src_to_dst, ST_SRC_EXT to ST_DST_EXT: the source word has arrived and a destination word is still pending.
- src_done, ST_SRC_EXT to ST_OPC: the source word was the last word.
- dst_done, ST_DST_EXT to ST_OPC: the destination word has arrived.

While no word is valid, every state holds where it is. Reset returns the controller to ST_OPC.

Top module: `insn_stream_decoder`

## Requirements
- R1: The top four bits of an opcode word select the format, and instr_fmt reports it.
  - 0100 to 1111 is two-operand, with instr_fmt=1.
  - 001x is a jump, with instr_fmt=3.
  - A word whose bits [15:10] are 000100 is one-operand, with instr_fmt=2, and its sub-opcode sits in bits [9:7].
  - instr_op gives the instruction index. A two-operand instruction uses its opcode value (4 to 15). A one-operand instruction uses 16 plus the sub-opcode (16 rotate through carry, 19 sign extend, 20 push, 21 call, 22 return from interrupt). A jump uses 24 plus its condition in bits [12:10].
- R2: A two-operand word has this layout: source register in [11:8], destination-mode bit in [7], byte flag in [6], source mode in [5:4], destination register in [3:0]. A one-operand word carries its byte flag in [6], its mode in [5:4] and its register in [3:0], and that register is reported as src_reg with dst_reg=0.
- R3: Mode codes are 0 register, 1 indexed, 2 indirect, 3 auto-increment, 4 symbolic, 5 absolute, 6 immediate, 7 constant.
  - Source mode field 01 with register 0 is symbolic, and with register 2 it is absolute.
  - Source mode field 11 with register 0 is immediate.
  - Register 2 with field 10 or 11, and register 3 with any field, gives a constant.
  - A destination-mode bit of 1 gives symbolic with register 0, absolute with register 2, and indexed otherwise.
- R4: The constant values are as follows. Register 2 gives 4 for field 10 and 8 for field 11. Register 3 gives 0, 1, 2 and 0xFFFF for fields 00, 01, 10 and 11. const_val is 0 whenever the source is not a constant.
- R5: These each take one extension word: a source that is indexed, symbolic, absolute or immediate, and a destination with the mode bit set. The source word comes first. The source word appears on src_ext and the destination word on dst_ext, with 0 on either when it is absent. ext_words gives the count.
- R6: Extension words are never decoded as opcodes. No instruction is reported until its last extension word is accepted. Idle cycles between words are allowed.
- R7: A two-operand instruction costs cycles as follows:
  - 1 to start.
  - +1 for an indirect, auto-increment or immediate source.
  - +2 for an indexed, symbolic or absolute source.
  - +2 for a memory destination.
  - +1 for writing a memory destination.
  - +1 for writing register 0 in register mode.
  - Compare (opcode 9) and bit test (opcode 11) write nothing.
- R8: A one-operand instruction costs 1 plus the same source cost as in R7, plus extra cycles by sub-opcode:
  - Rotate, swap, arithmetic rotate and sign extend add 1 for a memory operand, or 1 for register-mode register 0.
  - Push adds 1.
  - Call adds 2.
  - Return from interrupt costs exactly 3.
- R9: A jump is one word and costs 2 cycles. jump_disp is its 10-bit offset, sign-extended and doubled.
- R10: Any other word sets instr_illegal and is taken as a one-word instruction with 1 cycle. Its format, index, register, mode and extension fields are all 0.
- R11: Reset clears instr_valid and drops any instruction that was only partly received.
- R12: instr_valid is high for exactly one cycle, the cycle after the last word of an instruction is accepted. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | word_in carries a stream word this cycle |
| word_in | input | 16 | Instruction stream word |
| instr_valid | output | 1 | One-cycle report of a completed instruction |
| instr_illegal | output | 1 | Undefined opcode |
| instr_fmt | output | 2 | Format: 0 none, 1 two-operand, 2 one-operand, 3 jump |
| instr_op | output | 5 | Instruction index |
| instr_byte | output | 1 | Byte operation flag |
| src_reg | output | 4 | Source or single-operand register |
| dst_reg | output | 4 | Destination register |
| src_mode | output | 3 | Resolved source mode |
| dst_mode | output | 3 | Resolved destination mode |
| const_val | output | 16 | Generated constant |
| ext_words | output | 2 | Extension words consumed |
| src_ext | output | 16 | Source extension word |
| dst_ext | output | 16 | Destination extension word |
| jump_disp | output | 16 | Jump displacement in bytes |
| cycle_count | output | 4 | Predicted execution cycles |

## Verification
The stream is fed back-to-back instructions covering every source mode on general registers, on register 0, and on the two constant registers. This separates the plain modes from the special readings that depend on the register number. Sequences with no extension word, only a destination word, only a source word, and both words show whether extension words are counted and routed in the right order. Compare, bit test and writes to register 0 separate the write-back charges. Extension words chosen to look like jump and undefined opcodes, gaps between words, and a reset in the middle of an instruction show that boundaries are tracked rather than guessed.

// File: rtl/isd_pkg.sv
package isd_pkg;
    localparam int WORD_W = 16;
    localparam int REG_W  = 4;
    localparam int OPIX_W = 5;
    localparam int CYC_W  = 4;
    localparam int EXTN_W = 2;
    localparam int OPC_W  = 4;

    localparam logic [OPC_W-1:0] OPC_CMP = 4'h9;
    localparam logic [OPC_W-1:0] OPC_BIT = 4'hB;

    typedef enum logic [1:0] {
        FMT_NONE   = 2'd0,
        FMT_DUAL   = 2'd1,
        FMT_SINGLE = 2'd2,
        FMT_JUMP   = 2'd3
    } fmt_e;

    typedef enum logic [2:0] {
        AM_REG   = 3'd0,
        AM_IDX   = 3'd1,
        AM_IND   = 3'd2,
        AM_INC   = 3'd3,
        AM_SYM   = 3'd4,
        AM_ABS   = 3'd5,
        AM_IMM   = 3'd6,
        AM_CONST = 3'd7
    } amode_e;

    typedef struct packed {
        fmt_e              fmt;
        logic [OPIX_W-1:0] op;
        logic              illegal;
        logic              byte_op;
        logic [REG_W-1:0]  sreg;
        logic [REG_W-1:0]  dreg;
        amode_e            smode;
        amode_e            dmode;
        logic [WORD_W-1:0] kval;
        logic              need_src;
        logic              need_dst;
        logic [WORD_W-1:0] disp;
        logic [CYC_W-1:0]  cyc;
    } idec_t;

    // Source modes that pull one extension word from the stream.
    function automatic logic needs_ext(amode_e m);
        return (m == AM_IDX) || (m == AM_SYM) || (m == AM_ABS) || (m == AM_IMM);
    endfunction

    // Extra cycles spent reaching the source operand.
    function automatic logic [1:0] src_access_cost(amode_e m);
        unique case (m)
            AM_IND, AM_INC, AM_IMM: return 2'd1;
            AM_IDX, AM_SYM, AM_ABS: return 2'd2;
            default:                return 2'd0;
        endcase
    endfunction

    // Operand lives in memory (and so can be written back).
    function automatic logic in_memory(amode_e m);
        return (m == AM_IDX) || (m == AM_SYM) || (m == AM_ABS) ||
               (m == AM_IND) || (m == AM_INC);
    endfunction
endpackage

// File: rtl/isd_amode_map.sv
module isd_amode_map
    import isd_pkg::*;
#(
    parameter bit DEST_SIDE = 1'b0
) (
    input  logic [REG_W-1:0]  reg_num,
    input  logic [1:0]        sel,
    output amode_e            mode,
    output logic [WORD_W-1:0] kval
);
    generate
        if (DEST_SIDE) begin : g_dst
            // Destination: one mode bit, specialised by register 0 and 2.
            always_comb begin
                kval = '0;
                if (sel == 2'b00)        mode = AM_REG;
                else if (reg_num == 4'd0) mode = AM_SYM;
                else if (reg_num == 4'd2) mode = AM_ABS;
                else                      mode = AM_IDX;
            end
        end else begin : g_src
            always_comb begin
                kval = '0;
                mode = AM_REG;
                if (reg_num == 4'd3) begin
                    mode = AM_CONST;
                    unique case (sel)
                        2'b00: kval = 16'h0000;
                        2'b01: kval = 16'h0001;
                        2'b10: kval = 16'h0002;
                        default: kval = 16'hFFFF;
                    endcase
                end else if (reg_num == 4'd2) begin
                    unique case (sel)
                        2'b00: mode = AM_REG;
                        2'b01: mode = AM_ABS;
                        2'b10: begin mode = AM_CONST; kval = 16'h0004; end
                        default: begin mode = AM_CONST; kval = 16'h0008; end
                    endcase
                end else if (reg_num == 4'd0) begin
                    unique case (sel)
                        2'b00: mode = AM_REG;
                        2'b01: mode = AM_SYM;
                        2'b10: mode = AM_IND;
                        default: mode = AM_IMM;
                    endcase
                end else begin
                    unique case (sel)
                        2'b00: mode = AM_REG;
                        2'b01: mode = AM_IDX;
                        2'b10: mode = AM_IND;
                        default: mode = AM_INC;
                    endcase
                end
            end
        end
    endgenerate
endmodule

// File: rtl/isd_word_decode.sv
module isd_word_decode
    import isd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output idec_t             dec
);
    logic             is_dual, is_jump, is_single;
    logic [REG_W-1:0] src_sel_reg;
    amode_e           s_mode, d_mode;
    logic [WORD_W-1:0] s_k, d_k;

    assign is_dual   = (word[15:14] != 2'b00);
    assign is_jump   = (word[15:13] == 3'b001);
    assign is_single = (word[15:10] == 6'b000100) && (word[9:7] != 3'b111);
    assign src_sel_reg = is_dual ? word[11:8] : word[3:0];

    isd_amode_map #(.DEST_SIDE(1'b0)) u_src_map (
        .reg_num(src_sel_reg),
        .sel    (word[5:4]),
        .mode   (s_mode),
        .kval   (s_k)
    );

    isd_amode_map #(.DEST_SIDE(1'b1)) u_dst_map (
        .reg_num(word[3:0]),
        .sel    ({1'b0, word[7]}),
        .mode   (d_mode),
        .kval   (d_k)
    );

    always_comb begin
        dec = '0;
        if (is_dual) begin
            dec.fmt      = FMT_DUAL;
            dec.op       = {1'b0, word[15:12]};
            dec.byte_op  = word[6];
            dec.sreg     = word[11:8];
            dec.dreg     = word[3:0];
            dec.smode    = s_mode;
            dec.dmode    = d_mode;
            dec.kval     = s_k | d_k;
            dec.need_src = needs_ext(s_mode);
            dec.need_dst = word[7];
        end else if (is_jump) begin
            dec.fmt  = FMT_JUMP;
            dec.op   = {2'b11, word[12:10]};
            dec.disp = {{5{word[9]}}, word[9:0], 1'b0};
        end else if (is_single) begin
            dec.fmt      = FMT_SINGLE;
            dec.op       = {2'b10, word[9:7]};
            dec.byte_op  = word[6];
            dec.sreg     = word[3:0];
            dec.smode    = s_mode;
            dec.kval     = s_k;
            dec.need_src = needs_ext(s_mode);
        end else begin
            dec.illegal = 1'b1;
        end
    end
endmodule

// File: rtl/isd_cycle_cost.sv
module isd_cycle_cost
    import isd_pkg::*;
(
    input  fmt_e              fmt,
    input  logic [OPIX_W-1:0] op,
    input  amode_e            smode,
    input  logic [REG_W-1:0]  sreg,
    input  logic [REG_W-1:0]  dreg,
    input  logic              dst_mem,
    output logic [CYC_W-1:0]  cycles
);
    logic             writes_back;
    logic [CYC_W-1:0] base;

    always_comb begin
        writes_back = !((op == {1'b0, OPC_CMP}) || (op == {1'b0, OPC_BIT}));
        base        = CYC_W'(1) + CYC_W'(src_access_cost(smode));
        unique case (fmt)
            FMT_DUAL: begin
                cycles = base
                       + (dst_mem ? CYC_W'(2) : CYC_W'(0))
                       + ((dst_mem && writes_back) ? CYC_W'(1) : CYC_W'(0))
                       + ((!dst_mem && writes_back && dreg == '0) ? CYC_W'(1) : CYC_W'(0));
            end
            FMT_SINGLE: begin
                unique case (op[2:0])
                    3'd4:    cycles = base + CYC_W'(1);
                    3'd5:    cycles = base + CYC_W'(2);
                    3'd6:    cycles = CYC_W'(3);
                    default: cycles = base
                                    + (in_memory(smode) ? CYC_W'(1) : CYC_W'(0))
                                    + ((smode == AM_REG && sreg == '0) ? CYC_W'(1) : CYC_W'(0));
                endcase
            end
            FMT_JUMP: cycles = CYC_W'(2);
            default:  cycles = CYC_W'(1);
        endcase
    end
endmodule

// File: rtl/insn_stream_decoder.sv
module insn_stream_decoder
    import isd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_valid,
    input  logic [WORD_W-1:0]    word_in,
    output logic                 instr_valid,
    output logic                 instr_illegal,
    output logic [1:0]           instr_fmt,
    output logic [OPIX_W-1:0]    instr_op,
    output logic                 instr_byte,
    output logic [REG_W-1:0]     src_reg,
    output logic [REG_W-1:0]     dst_reg,
    output logic [2:0]           src_mode,
    output logic [2:0]           dst_mode,
    output logic [WORD_W-1:0]    const_val,
    output logic [EXTN_W-1:0]    ext_words,
    output logic [WORD_W-1:0]    src_ext,
    output logic [WORD_W-1:0]    dst_ext,
    output logic [WORD_W-1:0]    jump_disp,
    output logic [CYC_W-1:0]     cycle_count
);
    typedef enum logic [1:0] {
        ST_OPC     = 2'd0,
        ST_SRC_EXT = 2'd1,
        ST_DST_EXT = 2'd2
    } st_e;

    st_e               st_q, st_d;
    idec_t             dec_w, dec_full, hold_q, hold_d, fire_dec, out_q;
    logic [CYC_W-1:0]  dec_cyc;
    logic [WORD_W-1:0] sx_q, sx_d, fire_sx, fire_dx, out_sx, out_dx;
    logic [EXTN_W-1:0] out_extn;
    logic              fire, out_valid;

    isd_word_decode u_decode (
        .word(word_in),
        .dec (dec_w)
    );

    isd_cycle_cost u_cost (
        .fmt    (dec_w.fmt),
        .op     (dec_w.op),
        .smode  (dec_w.smode),
        .sreg   (dec_w.sreg),
        .dreg   (dec_w.dreg),
        .dst_mem(dec_w.need_dst),
        .cycles (dec_cyc)
    );

    always_comb begin
        dec_full     = dec_w;
        dec_full.cyc = dec_cyc;
    end

    // Next-state and completion logic.
    always_comb begin
        st_d     = st_q;
        hold_d   = hold_q;
        sx_d     = sx_q;
        fire     = 1'b0;
        fire_dec = hold_q;
        fire_sx  = sx_q;
        fire_dx  = '0;
        unique case (st_q)
            ST_OPC: begin
                if (word_valid) begin
                    hold_d = dec_full;
                    sx_d   = '0;
                    if (dec_full.need_src) begin
                        st_d = ST_SRC_EXT;                  // opc_to_src
                    end else if (dec_full.need_dst) begin
                        st_d = ST_DST_EXT;                  // opc_to_dst
                    end else begin
                        fire     = 1'b1;                    // opc_done
                        fire_dec = dec_full;
                        fire_sx  = '0;
                    end
                end
            end
            ST_SRC_EXT: begin
                if (word_valid) begin
                    if (hold_q.need_dst) begin
                        sx_d = word_in;
                        st_d = ST_DST_EXT;                  // src_to_dst
                    end else begin
                        fire    = 1'b1;                     // src_done
                        fire_sx = word_in;
                        st_d    = ST_OPC;
                    end
                end
            end
            ST_DST_EXT: begin
                if (word_valid) begin
                    fire    = 1'b1;                         // dst_done
                    fire_dx = word_in;
                    st_d    = ST_OPC;
                end
            end
            default: st_d = ST_OPC;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_OPC;
            hold_q <= '0;
            sx_q   <= '0;
        end else begin
            st_q   <= st_d;
            hold_q <= hold_d;
            sx_q   <= sx_d;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_q     <= '0;
            out_sx    <= '0;
            out_dx    <= '0;
            out_extn  <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_q    <= fire_dec;
                out_sx   <= fire_sx;
                out_dx   <= fire_dx;
                out_extn <= EXTN_W'(fire_dec.need_src) + EXTN_W'(fire_dec.need_dst);
            end
        end
    end

    assign instr_valid   = out_valid;
    assign instr_illegal = out_q.illegal;
    assign instr_fmt     = out_q.fmt;
    assign instr_op      = out_q.op;
    assign instr_byte    = out_q.byte_op;
    assign src_reg       = out_q.sreg;
    assign dst_reg       = out_q.dreg;
    assign src_mode      = out_q.smode;
    assign dst_mode      = out_q.dmode;
    assign const_val     = out_q.kval;
    assign ext_words     = out_extn;
    assign src_ext       = out_sx;
    assign dst_ext       = out_dx;
    assign jump_disp     = out_q.disp;
    assign cycle_count   = out_q.cyc;

    // R12: a report always follows an accepted word.
    a_r12_report_follows_word: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |-> $past(word_valid));

    // R6: while waiting for an extension word, an empty cycle reports nothing.
    a_r6_stall_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_OPC && !word_valid) |=> !instr_valid);

    // R9: jumps are single-word, two-cycle instructions.
    a_r9_jump_cost: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_fmt == FMT_JUMP) |-> (cycle_count == 4'd2 && ext_words == '0));

    // R10: an undefined opcode occupies exactly one word.
    a_r10_illegal_one_word: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_illegal) |-> (ext_words == '0 && instr_fmt == FMT_NONE && cycle_count == 4'd1));

    // R5: two extension words end in the destination-word state.
    a_r5_two_words_order: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && ext_words == 2'd2) |-> ($past(st_q) == ST_DST_EXT));
endmodule

// File: tb/tb_insn_stream_decoder.sv
`timescale 1ns/1ps
module tb_insn_stream_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [15:0] word_in = '0;
    logic        instr_valid, instr_illegal, instr_byte;
    logic [1:0]  instr_fmt, ext_words;
    logic [4:0]  instr_op;
    logic [3:0]  src_reg, dst_reg, cycle_count;
    logic [2:0]  src_mode, dst_mode;
    logic [15:0] const_val, src_ext, dst_ext, jump_disp;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    insn_stream_decoder dut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
        .instr_valid(instr_valid), .instr_illegal(instr_illegal), .instr_fmt(instr_fmt),
        .instr_op(instr_op), .instr_byte(instr_byte), .src_reg(src_reg), .dst_reg(dst_reg),
        .src_mode(src_mode), .dst_mode(dst_mode), .const_val(const_val), .ext_words(ext_words),
        .src_ext(src_ext), .dst_ext(dst_ext), .jump_disp(jump_disp), .cycle_count(cycle_count)
    );

    typedef struct packed {
        logic [15:0] w0, w1, w2;
        logic [1:0]  nw, fmt;
        logic [4:0]  op;
        logic        byt;
        logic [3:0]  sr, dr;
        logic [2:0]  sm, dm;
        logic [15:0] kv, se, de;
        logic [3:0]  cy;
        logic [15:0] disp;
        logic        ill;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TABLE [NV] = '{
        '{16'h540A,16'h0000,16'h0000,2'd1,2'd1,5'd5,1'b0,4'd4,4'd10,3'd0,3'd0,16'h0000,16'h0000,16'h0000,4'd1,16'h0000,1'b0},
        '{16'h541A,16'h0006,16'h0000,2'd2,2'd1,5'd5,1'b0,4'd4,4'd10,3'd1,3'd0,16'h0000,16'h0006,16'h0000,4'd3,16'h0000,1'b0},
        '{16'h542A,16'h0000,16'h0000,2'd1,2'd1,5'd5,1'b0,4'd4,4'd10,3'd2,3'd0,16'h0000,16'h0000,16'h0000,4'd2,16'h0000,1'b0},
        '{16'h543A,16'h0000,16'h0000,2'd1,2'd1,5'd5,1'b0,4'd4,4'd10,3'd3,3'd0,16'h0000,16'h0000,16'h0000,4'd2,16'h0000,1'b0},
        '{16'h501A,16'h0012,16'h0000,2'd2,2'd1,5'd5,1'b0,4'd0,4'd10,3'd4,3'd0,16'h0000,16'h0012,16'h0000,4'd3,16'h0000,1'b0},
        '{16'h521A,16'h801E,16'h0000,2'd2,2'd1,5'd5,1'b0,4'd2,4'd10,3'd5,3'd0,16'h0000,16'h801E,16'h0000,4'd3,16'h0000,1'b0},
        '{16'h503A,16'h0064,16'h0000,2'd2,2'd1,5'd5,1'b0,4'd0,4'd10,3'd6,3'd0,16'h0000,16'h0064,16'h0000,4'd2,16'h0000,1'b0},
        '{16'h531A,16'h0000,16'h0000,2'd1,2'd1,5'd5,1'b0,4'd3,4'd10,3'd7,3'd0,16'h0001,16'h0000,16'h0000,4'd1,16'h0000,1'b0},
        '{16'h5090,16'h000C,16'h0218,2'd3,2'd1,5'd5,1'b0,4'd0,4'd0,3'd4,3'd4,16'h0000,16'h000C,16'h0218,4'd6,16'h0000,1'b0},
        '{16'h40B2,16'h5A80,16'h0120,2'd3,2'd1,5'd4,1'b0,4'd0,4'd2,3'd6,3'd5,16'h0000,16'h5A80,16'h0120,4'd5,16'h0000,1'b0},
        '{16'h427F,16'h0000,16'h0000,2'd1,2'd1,5'd4,1'b1,4'd2,4'd15,3'd7,3'd0,16'h0008,16'h0000,16'h0000,4'd1,16'h0000,1'b0},
        '{16'h4303,16'h0000,16'h0000,2'd1,2'd1,5'd4,1'b0,4'd3,4'd3,3'd7,3'd0,16'h0000,16'h0000,16'h0000,4'd1,16'h0000,1'b0},
        '{16'h4323,16'h0000,16'h0000,2'd1,2'd1,5'd4,1'b0,4'd3,4'd3,3'd7,3'd0,16'h0002,16'h0000,16'h0000,4'd1,16'h0000,1'b0},
        '{16'h4333,16'h0000,16'h0000,2'd1,2'd1,5'd4,1'b0,4'd3,4'd3,3'd7,3'd0,16'hFFFF,16'h0000,16'h0000,4'd1,16'h0000,1'b0},
        '{16'h4222,16'h0000,16'h0000,2'd1,2'd1,5'd4,1'b0,4'd2,4'd2,3'd7,3'd0,16'h0004,16'h0000,16'h0000,4'd1,16'h0000,1'b0},
        '{16'h4130,16'h0000,16'h0000,2'd1,2'd1,5'd4,1'b0,4'd1,4'd0,3'd3,3'd0,16'h0000,16'h0000,16'h0000,4'd3,16'h0000,1'b0},
        '{16'h4500,16'h0000,16'h0000,2'd1,2'd1,5'd4,1'b0,4'd5,4'd0,3'd0,3'd0,16'h0000,16'h0000,16'h0000,4'd2,16'h0000,1'b0},
        '{16'h9400,16'h0000,16'h0000,2'd1,2'd1,5'd9,1'b0,4'd4,4'd0,3'd0,3'd0,16'h0000,16'h0000,16'h0000,4'd1,16'h0000,1'b0},
        '{16'h9480,16'h0010,16'h0000,2'd2,2'd1,5'd9,1'b0,4'd4,4'd0,3'd0,3'd4,16'h0000,16'h0000,16'h0010,4'd3,16'h0000,1'b0},
        '{16'hE4D5,16'h0002,16'h0004,2'd3,2'd1,5'd14,1'b1,4'd4,4'd5,3'd1,3'd1,16'h0000,16'h0002,16'h0004,4'd6,16'h0000,1'b0},
        '{16'h1005,16'h0000,16'h0000,2'd1,2'd2,5'd16,1'b0,4'd5,4'd0,3'd0,3'd0,16'h0000,16'h0000,16'h0000,4'd1,16'h0000,1'b0},
        '{16'h1016,16'h0004,16'h0000,2'd2,2'd2,5'd16,1'b0,4'd6,4'd0,3'd1,3'd0,16'h0000,16'h0004,16'h0000,4'd4,16'h0000,1'b0},
        '{16'h11A6,16'h0000,16'h0000,2'd1,2'd2,5'd19,1'b0,4'd6,4'd0,3'd2,3'd0,16'h0000,16'h0000,16'h0000,4'd3,16'h0000,1'b0},
        '{16'h1204,16'h0000,16'h0000,2'd1,2'd2,5'd20,1'b0,4'd4,4'd0,3'd0,3'd0,16'h0000,16'h0000,16'h0000,4'd2,16'h0000,1'b0},
        '{16'h12B0,16'hC012,16'h0000,2'd2,2'd2,5'd21,1'b0,4'd0,4'd0,3'd6,3'd0,16'h0000,16'hC012,16'h0000,4'd4,16'h0000,1'b0},
        '{16'h1300,16'h0000,16'h0000,2'd1,2'd2,5'd22,1'b0,4'd0,4'd0,3'd0,3'd0,16'h0000,16'h0000,16'h0000,4'd3,16'h0000,1'b0},
        '{16'h3FFC,16'h0000,16'h0000,2'd1,2'd3,5'd31,1'b0,4'd0,4'd0,3'd0,3'd0,16'h0000,16'h0000,16'h0000,4'd2,16'hFFF8,1'b0},
        '{16'h23FE,16'h0000,16'h0000,2'd1,2'd3,5'd24,1'b0,4'd0,4'd0,3'd0,3'd0,16'h0000,16'h0000,16'h0000,4'd2,16'hFFFC,1'b0},
        '{16'h0123,16'h0000,16'h0000,2'd1,2'd0,5'd0,1'b0,4'd0,4'd0,3'd0,3'd0,16'h0000,16'h0000,16'h0000,4'd1,16'h0000,1'b1},
        '{16'h1380,16'h0000,16'h0000,2'd1,2'd0,5'd0,1'b0,4'd0,4'd0,3'd0,3'd0,16'h0000,16'h0000,16'h0000,4'd1,16'h0000,1'b1}
    };

    vec_t v;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] w);
        word_valid = 1'b1;
        word_in    = w;
        @(posedge clk);
        #1;
        word_valid = 1'b0;
        word_in    = '0;
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
    endtask

    function automatic string cyc_req(input logic [1:0] f);
        if (f == 2'd1) return "R7";
        if (f == 2'd2) return "R8";
        if (f == 2'd3) return "R9";
        return "R10";
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "valid in reset", 32'(instr_valid), 32'd0);
        rst_n = 1'b1;
        idle();
        chk("R11", "valid after reset", 32'(instr_valid), 32'd0);

        // Table walk, back-to-back instructions
        for (int i = 0; i < NV; i++) begin
            v = TABLE[i];
            put(v.w0);
            if (v.nw > 2'd1) begin
                chk("R6", "early report", 32'(instr_valid), 32'd0);
                put(v.w1);
            end
            if (v.nw > 2'd2) begin
                chk("R6", "early report", 32'(instr_valid), 32'd0);
                put(v.w2);
            end
            chk("R12", "valid", 32'(instr_valid), 32'd1);
            chk("R1", "fmt/op", 32'({instr_fmt, instr_op}), 32'({v.fmt, v.op}));
            chk("R2", "byte/regs", 32'({instr_byte, src_reg, dst_reg}), 32'({v.byt, v.sr, v.dr}));
            chk("R3", "modes", 32'({src_mode, dst_mode}), 32'({v.sm, v.dm}));
            chk("R4", "constant", 32'(const_val), 32'(v.kv));
            chk("R5", "ext count", 32'(ext_words), 32'(v.nw - 2'd1));
            chk("R5", "ext words", {src_ext, dst_ext}, {v.se, v.de});
            chk(cyc_req(v.fmt), "cycles", 32'(cycle_count), 32'(v.cy));
            chk("R9", "disp", 32'(jump_disp), 32'(v.disp));
            chk("R10", "illegal", 32'(instr_illegal), 32'(v.ill));
        end

        // R12: nothing reported on an empty cycle
        idle();
        chk("R12", "idle valid", 32'(instr_valid), 32'd0);

        // R6: gaps between extension words
        put(16'h5090);
        idle(); chk("R6", "gap1", 32'(instr_valid), 32'd0);
        idle(); chk("R6", "gap2", 32'(instr_valid), 32'd0);
        put(16'h000C);
        idle(); chk("R6", "gap3", 32'(instr_valid), 32'd0);
        put(16'h0218);
        chk("R6", "stalled valid", 32'(instr_valid), 32'd1);
        chk("R5", "stalled ext", {src_ext, dst_ext}, 32'h000C0218);
        chk("R7", "stalled cycles", 32'(cycle_count), 32'd6);

        // R6: extension words that look like a jump and an undefined opcode
        put(16'h40B2);
        put(16'h3FFC);
        chk("R6", "disguised early", 32'(instr_valid), 32'd0);
        put(16'h0000);
        chk("R6", "disguised valid", 32'(instr_valid), 32'd1);
        chk("R6", "disguised fmt", 32'({instr_fmt, instr_illegal}), 32'({2'd1, 1'b0}));
        chk("R5", "disguised ext", {src_ext, dst_ext}, 32'h3FFC0000);

        // R11: reset in the middle of an instruction drops it
        put(16'h541A);
        rst_n = 1'b0;
        idle();
        chk("R11", "mid reset valid", 32'(instr_valid), 32'd0);
        idle();
        rst_n = 1'b1;
        idle();
        put(16'h540A);
        chk("R11", "after reset valid", 32'(instr_valid), 32'd1);
        chk("R11", "after reset op/ext", 32'({instr_op, ext_words, src_mode}), 32'({5'd5, 2'd0, 3'd0}));

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule